// File: doc/BRIEF.md
# SPI FIFO DMA Request Controller

This block sits between a byte-wide serial shift engine and a DMA engine. It holds a receive queue and a transmit queue, each `DEPTH` entries of `DW` bits. Received bytes arrive from the shift engine over a valid/ready port. The DMA engine drains them through a request/acknowledge handshake. In the other direction, the DMA engine fills the transmit queue through its own handshake, and the shift engine drains it over a valid/ready port.

Software programs each direction through a flat register port. The controls per direction are:
- a queue enable;
- a DMA enable;
- a level threshold;
- a write-one flush.

Software can also read back the live occupancy of each queue. A status word carries a sticky level flag and a live empty bit for each direction.

Receive requests fire while the receive queue holds strictly more entries than its threshold. Transmit requests fire while the transmit queue holds no more entries than its threshold.

Top module: `spi_dq_top`

## Requirements
- R1: After reset, both queues are empty, every enable and threshold is 0, both requests are low, and the status word (address 2) reads 0x0000000A.
- R2: `rx_in_ready` is high when the RX queue enable is 1 and the queue holds fewer than `DEPTH` entries. Accepted bytes appear on `rx_dma_data` in arrival order. An acknowledge while `rx_dma_req` is high pops one entry.
- R3: `rx_dma_req` is high exactly when the RX DMA enable and the RX queue enable are both 1 and the RX occupancy is strictly greater than the RX threshold.
- R4: `tx_dma_req` is high exactly when both TX enables are 1 and the TX occupancy is at or below the TX threshold. An acknowledge while the request is high pushes `tx_dma_data`. `tx_out_valid` is high when the TX queue enable is 1 and the queue is non-empty, and bytes leave in push order.
- R5: Control words sit at address 0 (RX) and address 1 (TX). Each has these fields:
  - threshold in bits [4:0];
  - queue enable in bit 8;
  - DMA enable in bit 9;
  - flush in bit 10;
  - live occupancy in bits [21:16], read-only.
- R6: Writing a control word with bit 10 set empties that queue and clears its level flag. From the next cycle the empty status bit reads 1. Bit 10 always reads 0.
- R7: Writing a control word with bit 10 clear leaves the queue contents and occupancy unchanged.
- R8: A threshold write of 0x1F is stored as 0x1E.
- R9: Writing a control word with its DMA enable at 0 drops that direction's request from the next cycle.
- R10: The status word at address 2 has these bits:
  - bit 0: RX level flag;
  - bit 1: RX empty;
  - bit 2: TX level flag;
  - bit 3: TX empty.

  A level flag sets one cycle after its request condition (ignoring the DMA enable) holds. It stays set until a 1 is written to its bit.
- R11: A push to a full queue and a pop from an empty queue are refused and leave the occupancy unchanged.
- R12: With a queue enable at 0, that direction's ready/valid output and DMA request stay low and its level flag does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rx_in_valid | input | 1 | Shift engine offers a received byte |
| rx_in_data | input | DW | Received byte |
| rx_in_ready | output | 1 | RX queue accepts the byte |
| rx_dma_req | output | 1 | RX DMA request |
| rx_dma_ack | input | 1 | RX DMA acknowledge, pops one byte |
| rx_dma_data | output | DW | Head of the RX queue |
| tx_dma_req | output | 1 | TX DMA request |
| tx_dma_ack | input | 1 | TX DMA acknowledge, pushes one byte |
| tx_dma_data | input | DW | Byte written by the DMA engine |
| tx_out_valid | output | 1 | TX queue offers a byte to the shift engine |
| tx_out_data | output | DW | Head of the TX queue |
| tx_out_ready | input | 1 | Shift engine takes the byte |

## Verification
The hardest state to reach is a queue sitting at its exact full boundary while a request, a flush or a DMA-enable change arrives in the same cycle. The shift engine and the DMA engine push and pop independently, so random traffic rarely parks the occupancy at 32 or 0 and holds it there.

Directed sequences therefore do several things:
- fill the RX queue past capacity;
- program the illegal threshold;
- drop the DMA enable with a request pending;
- flush a full queue;
- acknowledge an empty queue.

After that, thousands of random cycles mix both handshakes with sparse register writes. A reference model predicts every output and every register read in each cycle.

// File: rtl/spi_dq_pkg.sv
package spi_dq_pkg;
    // control word field positions
    localparam int FEN_BIT = 8;
    localparam int DEN_BIT = 9;
    localparam int CLR_BIT = 10;
    localparam int CNT_LSB = 16;

    // register addresses
    localparam logic [1:0] A_RX = 2'd0;
    localparam logic [1:0] A_TX = 2'd1;
    localparam logic [1:0] A_ST = 2'd2;
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = s_q.wp + 1'b1;
            if (pop)  s_d.rp = s_q.rp + 1'b1;
            s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[s_q.wp] <= wdata;
    end

    assign rdata = mem_q[s_q.rp];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R11
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/dq_chan.sv
module dq_chan #(
    parameter int DEPTH = 32,
    parameter bit IS_TX = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic [$clog2(DEPTH)-1:0]     cfg_thr,
    input  logic                         cfg_fen,
    input  logic                         cfg_den,
    input  logic                         cfg_clr,
    input  logic                         flag_clr,
    input  logic [$clog2(DEPTH):0]       count,
    output logic [$clog2(DEPTH)-1:0]     thr,
    output logic                         fen,
    output logic                         den,
    output logic                         flush,
    output logic                         req,
    output logic                         flag
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = TW + 1;
    localparam logic [TW-1:0] THR_MAX = TW'(DEPTH - 2);

    typedef struct packed {
        logic [TW-1:0] thr;
        logic          fen;
        logic          den;
        logic          flag;
    } chan_st_t;

    chan_st_t s_q, s_d;
    logic     lvl_ok;
    logic     hit;

    generate
        if (IS_TX) begin : g_tx_cmp
            assign lvl_ok = (count <= CW'(s_q.thr));
        end else begin : g_rx_cmp
            assign lvl_ok = (count > CW'(s_q.thr));
        end
    endgenerate

    assign hit   = s_q.fen & lvl_ok;
    assign flush = cfg_wr & cfg_clr;

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            s_d.thr = (cfg_thr > THR_MAX) ? THR_MAX : cfg_thr;
            s_d.fen = cfg_fen;
            s_d.den = cfg_den;
        end
        if (flush) s_d.flag = 1'b0;
        else       s_d.flag = (s_q.flag & ~flag_clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign thr  = s_q.thr;
    assign fen  = s_q.fen;
    assign den  = s_q.den;
    assign flag = s_q.flag;
    assign req  = s_q.den & hit;

    // R8
    thr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.thr <= THR_MAX);
    // R9
    den_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_den) |=> !req);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flush) |=> flag);
    // R12
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_fen) |=> !req);
endmodule

// File: rtl/spi_dq_top.sv
module spi_dq_top
    import spi_dq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          rx_in_valid,
    input  logic [DW-1:0] rx_in_data,
    output logic          rx_in_ready,
    output logic          rx_dma_req,
    input  logic          rx_dma_ack,
    output logic [DW-1:0] rx_dma_data,
    output logic          tx_dma_req,
    input  logic          tx_dma_ack,
    input  logic [DW-1:0] tx_dma_data,
    output logic          tx_out_valid,
    output logic [DW-1:0] tx_out_data,
    input  logic          tx_out_ready
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = TW + 1;

    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic [TW-1:0] rx_thr, tx_thr;
    logic          rx_fen, rx_den, tx_fen, tx_den;
    logic          rx_flush, tx_flush, rx_flag, tx_flag;
    logic          rx_push, rx_pop, tx_push, tx_pop;
    logic          rx_cfg_wr, tx_cfg_wr, st_wr;
    logic          unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:CLR_BIT+1], reg_wdata[FEN_BIT-1:TW]};

    assign rx_cfg_wr = reg_wr && (reg_addr == A_RX);
    assign tx_cfg_wr = reg_wr && (reg_addr == A_TX);
    assign st_wr     = reg_wr && (reg_addr == A_ST);

    // receive direction
    assign rx_in_ready = rx_fen & ~rx_full;
    assign rx_push     = rx_in_valid & rx_in_ready;
    assign rx_pop      = rx_dma_ack & rx_dma_req;

    dq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .pop(rx_pop), .wdata(rx_in_data),
        .rdata(rx_dma_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    dq_chan #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(rx_cfg_wr),
        .cfg_thr(reg_wdata[TW-1:0]), .cfg_fen(reg_wdata[FEN_BIT]),
        .cfg_den(reg_wdata[DEN_BIT]), .cfg_clr(reg_wdata[CLR_BIT]),
        .flag_clr(st_wr & reg_wdata[0]), .count(rx_cnt),
        .thr(rx_thr), .fen(rx_fen), .den(rx_den), .flush(rx_flush),
        .req(rx_dma_req), .flag(rx_flag)
    );

    // transmit direction
    assign tx_out_valid = tx_fen & ~tx_empty;
    assign tx_pop       = tx_out_valid & tx_out_ready;
    assign tx_push      = tx_dma_ack & tx_dma_req;

    dq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .pop(tx_pop), .wdata(tx_dma_data),
        .rdata(tx_out_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    dq_chan #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(tx_cfg_wr),
        .cfg_thr(reg_wdata[TW-1:0]), .cfg_fen(reg_wdata[FEN_BIT]),
        .cfg_den(reg_wdata[DEN_BIT]), .cfg_clr(reg_wdata[CLR_BIT]),
        .flag_clr(st_wr & reg_wdata[2]), .count(tx_cnt),
        .thr(tx_thr), .fen(tx_fen), .den(tx_den), .flush(tx_flush),
        .req(tx_dma_req), .flag(tx_flag)
    );

    // register read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_RX: begin
                reg_rdata[TW-1:0]      = rx_thr;
                reg_rdata[FEN_BIT]     = rx_fen;
                reg_rdata[DEN_BIT]     = rx_den;
                reg_rdata[CNT_LSB+:CW] = rx_cnt;
            end
            A_TX: begin
                reg_rdata[TW-1:0]      = tx_thr;
                reg_rdata[FEN_BIT]     = tx_fen;
                reg_rdata[DEN_BIT]     = tx_den;
                reg_rdata[CNT_LSB+:CW] = tx_cnt;
            end
            A_ST:    reg_rdata[3:0] = {tx_empty, tx_flag, rx_empty, rx_flag};
            default: reg_rdata = '0;
        endcase
    end

    // R3
    rx_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> !rx_empty);
    // R4
    tx_req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> !tx_full);
    // R2
    rx_pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !rx_flush) |=> (rx_cnt == $past(rx_cnt) - 1'b1));
    // R7
    no_clear_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cfg_wr && !reg_wdata[CLR_BIT] && !rx_push && !rx_pop) |=> $stable(rx_cnt));
endmodule

// File: tb/sim_spi_dq_top.sv
`timescale 1ns/1ps
module sim_spi_dq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_ready, rx_dma_req, tx_dma_req, tx_out_valid;
    logic        rx_dma_ack = 1'b0;
    logic [7:0]  rx_dma_data, tx_out_data;
    logic        tx_dma_ack = 1'b0;
    logic [7:0]  tx_dma_data = '0;
    logic        tx_out_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    byte unsigned rxq[$];
    byte unsigned txq[$];
    int rthr = 0, tthr = 0;
    bit rfen = 0, rden = 0, tfen = 0, tden = 0, rflag = 0, tflag = 0;

    spi_dq_top u0 (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input logic [4:0] v);
        return (v == 5'h1F) ? 30 : int'(v);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] r = '0;
        case (a)
            2'd0: begin r[4:0] = rthr[4:0]; r[8] = rfen; r[9] = rden; r[21:16] = rxq.size(); end
            2'd1: begin r[4:0] = tthr[4:0]; r[8] = tfen; r[9] = tden; r[21:16] = txq.size(); end
            2'd2: r[3:0] = {txq.size() == 0, tflag, rxq.size() == 0, rflag};
            default: r = '0;
        endcase
        return r;
    endfunction

    // check all outputs against the model, advance the model, cross one clock
    task automatic step();
        bit e_rdy, e_rreq, e_treq, e_tv, rhit, thit, rfl, tfl, rclr, tclr;
        #1;
        e_rdy  = rfen && rxq.size() < 32;
        e_rreq = rden && rfen && rxq.size() > rthr;
        e_treq = tden && tfen && txq.size() <= tthr;
        e_tv   = tfen && txq.size() > 0;
        chk(rx_in_ready === e_rdy, "R2 rx_in_ready", 32'(rx_in_ready), 32'(e_rdy));
        chk(rx_dma_req === e_rreq, "R3 rx_dma_req", 32'(rx_dma_req), 32'(e_rreq));
        if (e_rreq) chk(rx_dma_data === rxq[0], "R2 rx_dma_data", 32'(rx_dma_data), 32'(rxq[0]));
        chk(tx_dma_req === e_treq, "R4 tx_dma_req", 32'(tx_dma_req), 32'(e_treq));
        chk(tx_out_valid === e_tv, "R4 tx_out_valid", 32'(tx_out_valid), 32'(e_tv));
        if (e_tv) chk(tx_out_data === txq[0], "R4 tx_out_data", 32'(tx_out_data), 32'(txq[0]));
        chk(reg_rdata === exp_rd(reg_addr), (reg_addr == 2) ? "R10 status read" : "R5 control read",
            reg_rdata, exp_rd(reg_addr));
        rhit = rfen && rxq.size() > rthr;
        thit = tfen && txq.size() <= tthr;
        rfl  = reg_wr && reg_addr == 0 && reg_wdata[10];
        tfl  = reg_wr && reg_addr == 1 && reg_wdata[10];
        rclr = reg_wr && reg_addr == 2 && reg_wdata[0];
        tclr = reg_wr && reg_addr == 2 && reg_wdata[2];
        rflag = rfl ? 1'b0 : ((rflag && !rclr) || rhit);
        tflag = tfl ? 1'b0 : ((tflag && !tclr) || thit);
        if (rfl) rxq.delete();
        else begin
            if (rx_dma_ack && e_rreq) void'(rxq.pop_front());
            if (rx_in_valid && e_rdy) rxq.push_back(rx_in_data);
        end
        if (tfl) txq.delete();
        else begin
            if (tx_out_ready && e_tv) void'(txq.pop_front());
            if (tx_dma_ack && e_treq) txq.push_back(tx_dma_data);
        end
        if (reg_wr && reg_addr == 0) begin rthr = sat(reg_wdata[4:0]); rfen = reg_wdata[8]; rden = reg_wdata[9]; end
        if (reg_wr && reg_addr == 1) begin tthr = sat(reg_wdata[4:0]); tfen = reg_wdata[8]; tden = reg_wdata[9]; end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic peek(input logic [1:0] a);
        reg_addr = a;
        #1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog expired act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 disabled queues are quiet
        peek(2'd2);
        chk(reg_rdata === 32'hA, "R1 status after reset", reg_rdata, 32'hA);
        chk(!rx_dma_req && !tx_dma_req, "R1 requests low", {rx_dma_req, tx_dma_req}, 0);
        chk(rx_in_ready === 1'b0 && tx_out_valid === 1'b0, "R12 handshakes low while disabled",
            {rx_in_ready, tx_out_valid}, 0);

        // fill RX beyond capacity: R11
        wr(2'd0, 32'h0000_0103);
        rx_in_valid = 1'b1;
        for (int i = 0; i < 34; i++) begin rx_in_data = 8'($urandom); step(); end
        rx_in_valid = 1'b0;
        peek(2'd0);
        chk(reg_rdata[21:16] === 6'd32, "R11 full push refused", reg_rdata[21:16], 32);
        chk(rx_in_ready === 1'b0, "R11 ready low when full", rx_in_ready, 0);

        // illegal threshold: R8
        wr(2'd0, 32'h0000_031F);
        peek(2'd0);
        chk(reg_rdata[4:0] === 5'h1E, "R8 threshold saturates", reg_rdata[4:0], 32'h1E);
        chk(rx_dma_req === 1'b1, "R3 request when 32 > 30", rx_dma_req, 1);
        rx_dma_ack = 1'b1; step(); step(); rx_dma_ack = 1'b0;
        #1;
        chk(rx_dma_req === 1'b0, "R3 request off at level 30", rx_dma_req, 0);

        // DMA disable drops request: R9
        wr(2'd0, 32'h0000_0300);
        #1 chk(rx_dma_req === 1'b1, "R3 request at thr 0", rx_dma_req, 1);
        wr(2'd0, 32'h0000_0100);
        #1 chk(rx_dma_req === 1'b0, "R9 request dropped", rx_dma_req, 0);

        // write without flush bit: R7
        wr(2'd0, 32'h0000_0100);
        peek(2'd0);
        chk(reg_rdata[21:16] === 6'd30, "R7 contents kept", reg_rdata[21:16], 30);

        // flush: R6
        wr(2'd0, 32'h0000_0500);
        peek(2'd2);
        chk(reg_rdata[1:0] === 2'b10, "R6 empty set and flag clear", reg_rdata[1:0], 2);
        peek(2'd0);
        chk(reg_rdata[21:16] === 6'd0 && reg_rdata[10] === 1'b0, "R6 count zero, bit 10 reads 0",
            reg_rdata, 32'h100);

        // acknowledge on empty queue: R11
        wr(2'd0, 32'h0000_0300);
        rx_dma_ack = 1'b1; step(); rx_dma_ack = 1'b0;
        peek(2'd0);
        chk(reg_rdata[21:16] === 6'd0, "R11 pop from empty refused", reg_rdata[21:16], 0);

        // TX path: R12 then R4
        wr(2'd1, 32'h0000_0202);
        #1 chk(tx_dma_req === 1'b0, "R12 no TX request with queue disabled", tx_dma_req, 0);
        wr(2'd1, 32'h0000_0302);
        #1 chk(tx_dma_req === 1'b1, "R4 TX request at level 0", tx_dma_req, 1);
        tx_dma_ack = 1'b1;
        for (int i = 0; i < 3; i++) begin tx_dma_data = 8'($urandom); step(); end
        tx_dma_ack = 1'b0;
        #1 chk(tx_dma_req === 1'b0, "R4 TX request off at 3 > 2", tx_dma_req, 0);
        tx_out_ready = 1'b1; repeat (3) step(); tx_out_ready = 1'b0;

        // sticky flag and write-one clear: R10
        rx_in_valid = 1'b1; rx_in_data = 8'h5A; step(); rx_in_valid = 1'b0;
        step();
        peek(2'd2);
        chk(reg_rdata[0] === 1'b1, "R10 RX flag set", reg_rdata[0], 1);
        wr(2'd0, 32'h0000_0105);
        step();
        peek(2'd2);
        chk(reg_rdata[0] === 1'b1, "R10 RX flag sticky", reg_rdata[0], 1);
        wr(2'd2, 32'h1);
        peek(2'd2);
        chk(reg_rdata[0] === 1'b0, "R10 RX flag cleared by write-one", reg_rdata[0], 0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            rx_in_valid  = ($urandom % 3) != 0;
            rx_in_data   = 8'($urandom);
            rx_dma_ack   = ($urandom % 2) != 0;
            tx_dma_ack   = ($urandom % 2) != 0;
            tx_dma_data  = 8'($urandom);
            tx_out_ready = ($urandom % 3) != 0;
            d = $urandom;
            d[8]  = ($urandom % 8) != 0;
            d[10] = ($urandom % 24) == 0;
            reg_addr  = 2'($urandom);
            reg_wr    = ($urandom % 10) == 0;
            reg_wdata = reg_wr ? d : 32'h0;
            step();
        end
        reg_wr = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule